// File: doc/BRIEF.md
# Exception Entry and Mode Controller

This block sequences exception entry and exception return for a 32-bit processor core that has seven operating modes. The core hands it seven exception request lines, a return request, the address to come back to and the status word currently in force. The controller picks the winning request, banks the status word and the return address for the mode that request targets, and produces the next status word and the next PC. The core loads both when the done pulse appears.

There are five banks, one for each exception mode: fast interrupt, normal interrupt, supervisor, abort and undefined. Each bank holds a saved status word and a link address. The user and system modes share one register view and have no bank. On entry the block copies the status, raises the interrupt-disable bits, leaves the narrow instruction state, switches mode and jumps to a fixed vector. A return request restores the status and the PC from the bank of the mode named in the incoming status word. The core's decode, its ALU and its general registers are outside the block.

Top module: `exc_mode_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `psr_out` is 0x000000D3 (supervisor mode 10011, bits 7 and 6 set), `pc_out` is 0, and `done` and `err` are low.
- R2: An accepted exception loads `pc_out` with its vector and sets `psr_out[4:0]` to its target mode. Reset goes to 0x00 and mode 10011. Undefined goes to 0x04 and mode 11011. Software interrupt goes to 0x08 and mode 10011. Prefetch abort goes to 0x0C and mode 10111. Data abort goes to 0x10 and mode 10111. Normal interrupt goes to 0x18 and mode 10010. Fast interrupt goes to 0x1C and mode 10001.
- R3: When several unmasked requests are high together, exactly one is taken. The order from highest to lowest is reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined, software interrupt.
- R4: The entry status word equals `psr_in` with bit 7 set and bit 5 cleared. Bit 6 is set for reset and fast-interrupt entry and is copied from `psr_in` otherwise. Bits [31:8] are copied, and bits [4:0] hold the target mode.
- R5: On entry, `psr_in` is stored as the saved status of the target mode and `pc_in` is stored as that mode's link address.
- R6: A normal interrupt is ignored while `psr_in[7]` is 1, and a fast interrupt is ignored while `psr_in[6]` is 1. An ignored request produces no `done` and leaves `pc_out` and `psr_out` unchanged, and any lower-priority unmasked request is taken instead.
- R7: A return request whose `psr_in[4:0]` names one of the five banked modes loads `psr_out` with that mode's saved status and `pc_out` with its link address, and raises `done`.
- R8: A return request whose `psr_in[4:0]` is user (10000), system (11111) or any unknown code raises `err` for one cycle, keeps `done` low and leaves `pc_out` and `psr_out` unchanged.
- R9: `done` rises in the cycle after the request is sampled, which is the same cycle in which the new PC and status word appear, and it lasts one cycle. When an exception and a return request arrive together, the exception wins and no `err` is raised.
- R10: Entry into one mode leaves the saved status and the link address of every other bank untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_rst | input | 1 | Reset exception request |
| req_dabt | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Normal interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| ret_req | input | 1 | Exception return request |
| pc_in | input | AW | Return address to bank on entry |
| psr_in | input | 32 | Status word currently in force |
| pc_out | output | AW | Next PC, registered |
| psr_out | output | 32 | Next status word, registered |
| done | output | 1 | One-cycle pulse when an entry or a return completes |
| err | output | 1 | One-cycle pulse when a return is refused |

## Verification
The assertions assume that `psr_in` is the status word the core is actually running with. Its mode field decides both masking and which bank a return reads. They also assume that a return is only requested from a mode whose bank was written since reset. The stimulus meets both assumptions. It drives every input on the falling edge. It feeds each return with the status word produced by the preceding entry, or with a mode entered earlier in the same run, so a bank is never read before it is written. The refused-return cases use only user, system and one unknown mode code, which never reach a bank.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int PSR_W    = 32;
  localparam int NKIND    = 7;
  localparam int NBANK    = 5;
  localparam int BANK_IW  = 3;
  localparam int BIT_I    = 7;
  localparam int BIT_F    = 6;
  localparam int BIT_T    = 5;

  // request kinds, listed in priority order (index 0 wins)
  typedef enum logic [2:0] {
    K_RST  = 3'd0,
    K_DABT = 3'd1,
    K_FIQ  = 3'd2,
    K_IRQ  = 3'd3,
    K_PABT = 3'd4,
    K_UND  = 3'd5,
    K_SWI  = 3'd6
  } exc_kind_e;

  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_SYS = 5'b11111;

  localparam logic [PSR_W-1:0] RESET_PSR = 32'h0000_00D3;

  function automatic logic [4:0] kind_mode(exc_kind_e k);
    case (k)
      K_RST, K_SWI:   return M_SVC;
      K_DABT, K_PABT: return M_ABT;
      K_FIQ:          return M_FIQ;
      K_IRQ:          return M_IRQ;
      default:        return M_UND;
    endcase
  endfunction

  function automatic logic [7:0] kind_vec(exc_kind_e k);
    case (k)
      K_RST:   return 8'h00;
      K_UND:   return 8'h04;
      K_SWI:   return 8'h08;
      K_PABT:  return 8'h0C;
      K_DABT:  return 8'h10;
      K_IRQ:   return 8'h18;
      default: return 8'h1C;
    endcase
  endfunction

  function automatic logic kind_sets_f(exc_kind_e k);
    return (k == K_RST) || (k == K_FIQ);
  endfunction

  function automatic logic mode_banked(logic [4:0] m);
    return (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC) ||
           (m == M_ABT) || (m == M_UND);
  endfunction

  function automatic logic [BANK_IW-1:0] mode_idx(logic [4:0] m);
    case (m)
      M_FIQ:   return 3'd0;
      M_IRQ:   return 3'd1;
      M_SVC:   return 3'd2;
      M_ABT:   return 3'd3;
      M_UND:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int NK = NKIND
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NK-1:0] req,
  input  logic          irq_mask,
  input  logic          fiq_mask,
  output logic          valid,
  output exc_kind_e     kind
);

  logic [NK-1:0] eff;
  logic [NK-1:0] grant;

  always_comb begin
    eff = req;
    if (irq_mask) eff[int'(K_IRQ)] = 1'b0;
    if (fiq_mask) eff[int'(K_FIQ)] = 1'b0;
  end

  for (genvar i = 0; i < NK; i++) begin : g_grant
    if (i == 0) begin : g_top
      assign grant[i] = eff[i];
    end else begin : g_rest
      assign grant[i] = eff[i] & ~(|eff[i-1:0]);
    end
  end

  always_comb begin
    kind = K_RST;
    for (int i = 0; i < NK; i++) begin
      if (grant[i]) kind = exc_kind_e'(i[2:0]);
    end
  end

  assign valid = |grant;

  always_comb begin
    assert ($onehot0(grant));
  end

  AST_RST_WINS: assert property (@(posedge clk) disable iff (rst)
    req[int'(K_RST)] |-> (valid && kind == K_RST)); // R3

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (irq_mask && valid) |-> (kind != K_IRQ)); // R6

  AST_FIQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (fiq_mask && valid) |-> (kind != K_FIQ)); // R6

endmodule

// File: rtl/exc_bank.sv
module exc_bank
  import exc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = PSR_W,
  parameter int NB = NBANK,
  parameter int IW = BANK_IW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wpsr,
  input  logic [AW-1:0] wlr,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rpsr,
  output logic [AW-1:0] rlr
);

  logic [DW-1:0] psr_mem [NB];
  logic [AW-1:0] lr_mem  [NB];

  always_ff @(posedge clk) begin
    if (we) begin
      psr_mem[widx] <= wpsr;
      lr_mem[widx]  <= wlr;
    end
  end

  assign rpsr = psr_mem[ridx];
  assign rlr  = lr_mem[ridx];

endmodule

// File: rtl/exc_mode_ctrl.sv
module exc_mode_ctrl
  import exc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_rst,
  input  logic             req_dabt,
  input  logic             req_fiq,
  input  logic             req_irq,
  input  logic             req_pabt,
  input  logic             req_und,
  input  logic             req_swi,
  input  logic             ret_req,
  input  logic [AW-1:0]    pc_in,
  input  logic [PSR_W-1:0] psr_in,
  output logic [AW-1:0]    pc_out,
  output logic [PSR_W-1:0] psr_out,
  output logic             done,
  output logic             err
);

  localparam int VEC_PAD = AW - 8;

  logic [NKIND-1:0]   req_vec;
  logic               exc_valid;
  exc_kind_e          exc_kind;
  logic [4:0]         tgt_mode;
  logic [4:0]         cur_mode;
  logic               ret_ok;
  logic [PSR_W-1:0]   entry_psr;
  logic [AW-1:0]      entry_pc;
  logic [PSR_W-1:0]   bank_psr;
  logic [AW-1:0]      bank_lr;

  assign req_vec = {req_swi, req_und, req_pabt, req_irq, req_fiq, req_dabt, req_rst};

  exc_arbiter #(.NK(NKIND)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .req      (req_vec),
    .irq_mask (psr_in[BIT_I]),
    .fiq_mask (psr_in[BIT_F]),
    .valid    (exc_valid),
    .kind     (exc_kind)
  );

  assign tgt_mode = kind_mode(exc_kind);
  assign cur_mode = psr_in[4:0];
  assign ret_ok   = mode_banked(cur_mode);
  assign entry_pc = {{VEC_PAD{1'b0}}, kind_vec(exc_kind)};

  always_comb begin
    entry_psr        = psr_in;
    entry_psr[BIT_I] = 1'b1;
    if (kind_sets_f(exc_kind)) entry_psr[BIT_F] = 1'b1;
    entry_psr[BIT_T] = 1'b0;
    entry_psr[4:0]   = tgt_mode;
  end

  exc_bank #(.AW(AW), .DW(PSR_W), .NB(NBANK), .IW(BANK_IW)) u_bank (
    .clk  (clk),
    .we   (exc_valid && !rst),
    .widx (mode_idx(tgt_mode)),
    .wpsr (psr_in),
    .wlr  (pc_in),
    .ridx (mode_idx(cur_mode)),
    .rpsr (bank_psr),
    .rlr  (bank_lr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_out  <= '0;
      psr_out <= RESET_PSR;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (exc_valid) begin
        pc_out  <= entry_pc;
        psr_out <= entry_psr;
        done    <= 1'b1;
      end else if (ret_req) begin
        if (ret_ok) begin
          pc_out  <= bank_lr;
          psr_out <= bank_psr;
          done    <= 1'b1;
        end else begin
          err <= 1'b1;
        end
      end
    end
  end

  AST_ENTRY_IMASK: assert property (@(posedge clk) disable iff (rst)
    $past(exc_valid) |-> psr_out[BIT_I]); // R4

  AST_ENTRY_WIDE: assert property (@(posedge clk) disable iff (rst)
    $past(exc_valid) |-> !psr_out[BIT_T]); // R4

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    err |-> ($stable(pc_out) && $stable(psr_out) && !done)); // R8

  AST_EXC_BEATS_RET: assert property (@(posedge clk) disable iff (rst)
    $past(exc_valid) |-> !err); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (!$past(exc_valid) && !$past(ret_req)) |-> !done); // R9

endmodule

// File: tb/exc_mode_ctrl_tb.sv
`timescale 1ns/1ps
module exc_mode_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  reqv = '0;
  logic        ret_req = 1'b0;
  logic [31:0] pc_in = '0;
  logic [31:0] psr_in = '0;
  logic [31:0] pc_out, psr_out;
  logic        done, err;
  int          n_run = 0;
  int          n_fail = 0;
  bit          finished = 0;

  always #10 clk = ~clk;

  exc_mode_ctrl #(.AW(32)) u_dut (
    .clk(clk), .rst(rst),
    .req_rst(reqv[0]), .req_dabt(reqv[1]), .req_fiq(reqv[2]), .req_irq(reqv[3]),
    .req_pabt(reqv[4]), .req_und(reqv[5]), .req_swi(reqv[6]),
    .ret_req(ret_req), .pc_in(pc_in), .psr_in(psr_in),
    .pc_out(pc_out), .psr_out(psr_out), .done(done), .err(err)
  );

  function automatic logic [4:0] emode(int k);
    case (k)
      0, 6: return 5'b10011;
      1, 4: return 5'b10111;
      2:    return 5'b10001;
      3:    return 5'b10010;
      default: return 5'b11011;
    endcase
  endfunction

  function automatic logic [31:0] evec(int k);
    case (k)
      0: return 32'h00; 1: return 32'h10; 2: return 32'h1C; 3: return 32'h18;
      4: return 32'h0C; 5: return 32'h04; default: return 32'h08;
    endcase
  endfunction

  function automatic logic [31:0] eps(int k, logic [31:0] p);
    logic f;
    f = (k == 0 || k == 2) ? 1'b1 : p[6];
    return {p[31:8], 1'b1, f, 1'b0, emode(k)};
  endfunction

  function automatic int winner(logic [6:0] r, logic [31:0] p);
    for (int k = 0; k < 7; k++) begin
      if (r[k] && !(k == 2 && p[6]) && !(k == 3 && p[7])) return k;
    end
    return -1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_exc(logic [6:0] r, logic [31:0] p, logic [31:0] pc);
    reqv = r; psr_in = p; pc_in = pc; ret_req = 1'b0;
    tick();
    reqv = '0;
  endtask

  task automatic do_ret(logic [31:0] p);
    psr_in = p; ret_req = 1'b1;
    tick();
    ret_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pv, sv, p, pc, a;
    @(negedge clk);
    tick();
    // R1 reset state during reset
    chk("R1 psr", psr_out, 32'h0000_00D3);
    chk("R1 pc", pc_out, 32'h0);
    chk("R1 flags", {30'd0, done, err}, 32'h0);
    rst = 1'b0;
    tick();
    chk("R1 psr after release", psr_out, 32'h0000_00D3);
    chk("R1 done after release", {31'd0, done}, 32'h0);

    // single request sweep with every mask combination, followed by return
    for (int k = 0; k < 7; k++) begin
      for (int m = 0; m < 4; m++) begin
        p  = {8'hA5, 8'(k * 17), 8'(m * 33), m[1:0], 1'b1, 5'b10000};
        pc = 32'h1000 + k * 256 + m * 4;
        pv = pc_out; sv = psr_out;
        do_exc(7'(1 << k), p, pc);
        if ((k == 2 && m[0]) || (k == 3 && m[1])) begin
          chk("R6 masked no done", {31'd0, done}, 32'h0);
          chk("R6 masked pc", pc_out, pv);
          chk("R6 masked psr", psr_out, sv);
        end else begin
          chk("R9 done on entry", {31'd0, done}, 32'h1);
          chk("R2 vector", pc_out, evec(k));
          chk("R4 entry psr", psr_out, eps(k, p));
          a = psr_out;
          tick();
          chk("R9 done one cycle", {31'd0, done}, 32'h0);
          do_ret(a);
          chk("R7 done on return", {31'd0, done}, 32'h1);
          chk("R5 saved psr restored", psr_out, p);
          chk("R5 link restored", pc_out, pc);
        end
      end
    end

    // priority sweep over every request combination and mask setting
    for (int v = 1; v < 128; v++) begin
      for (int m = 0; m < 4; m++) begin
        int w;
        p = {24'h00C3_5A, m[1:0], 1'b0, 5'b10011};
        pv = pc_out; sv = psr_out;
        w = winner(7'(v), p);
        do_exc(7'(v), p, 32'h8000 + v);
        if (w < 0) begin
          chk("R6 all masked pc", pc_out, pv);
          chk("R6 all masked psr", psr_out, sv);
        end else begin
          chk("R3 winner vector", pc_out, evec(w));
          chk("R3 winner mode", {27'd0, psr_out[4:0]}, {27'd0, emode(w)});
        end
      end
    end

    // bank independence
    do_exc(7'b0000100, 32'h1111_1010, 32'h2000);
    do_exc(7'b0001000, 32'h2222_2011, 32'h3000);
    do_exc(7'b0100000, 32'h3333_3012, 32'h4000);
    do_ret(32'h0000_001B);
    chk("R10 und psr", psr_out, 32'h3333_3012);
    chk("R10 und link", pc_out, 32'h4000);
    do_ret(32'h0000_0012);
    chk("R10 irq psr", psr_out, 32'h2222_2011);
    chk("R10 irq link", pc_out, 32'h3000);
    do_ret(32'h0000_0011);
    chk("R10 fiq psr", psr_out, 32'h1111_1010);
    chk("R10 fiq link", pc_out, 32'h2000);

    // refused returns
    for (int j = 0; j < 3; j++) begin
      logic [4:0] md;
      md = (j == 0) ? 5'b10000 : (j == 1) ? 5'b11111 : 5'b00000;
      pv = pc_out; sv = psr_out;
      do_ret({27'h0, md});
      chk("R8 err", {31'd0, err}, 32'h1);
      chk("R8 no done", {31'd0, done}, 32'h0);
      chk("R8 pc held", pc_out, pv);
      chk("R8 psr held", psr_out, sv);
      tick();
      chk("R8 err one cycle", {31'd0, err}, 32'h0);
    end

    // exception and return together
    reqv = 7'b0100000; ret_req = 1'b1; psr_in = 32'h0000_0011; pc_in = 32'h5000;
    tick();
    reqv = '0; ret_req = 1'b0;
    chk("R9 exception beats return pc", pc_out, 32'h04);
    chk("R9 exception beats return err", {30'd0, done, err}, 32'h2);

    // reset again mid-run
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R1 psr after second reset", psr_out, 32'h0000_00D3);
    chk("R1 pc after second reset", pc_out, 32'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule